// File: doc/BRIEF.md
# Per-Processor Interrupt Mask Router

This block gathers up to 64 device interrupt request lines into one shared raw request vector and routes them to four processors. Each processor owns a 64-bit enable mask. Its pending vector is always its own mask ANDed with the shared raw vector, so it follows every mask write and every change on the request lines. A processor's interrupt output is asserted while any bit of its pending vector is set.

A second interrupt output carries a periodic timer event. A pulse on the tick input raises it, and software drops it through a write-one-to-clear bit in a miscellaneous register. When that register is read, it also returns the identifier of the processor making the access.

Software reaches the block through a simple memory-mapped port that accepts only 64-bit accesses. Registers sit on a 64-byte stride. Any access the block cannot honour leaves all state unchanged and sets a sticky error flag.

Top module: `irq_mask_router`

## Requirements
- R1: While `rst_n` is low and after it is released, `cpu_irq`, `rtc_irq`, `err_sticky` and `bus_rvalid` are 0, and every mask, the raw vector and the miscellaneous register read as 0.
- R2: The raw request register, at register index 10, holds the value `dev_irq` had at the previous clock edge. Bit n follows line n: it is set while the line is high and clear while the line is low.
- R3: The pending register of processor p, at index 6+p, reads as mask p AND the raw vector. It is read-only.
- R4: `cpu_irq[p]` is high exactly when pending p has any bit set. A mask write takes effect on the cycle after the write. Clearing a mask bit withdraws the interrupt that bit was causing.
- R5: The mask of processor p sits at index 2+p and holds a full 64-bit value. Writing one processor's mask leaves the other masks unchanged.
- R6: A read of the miscellaneous register, at index 1, returns the stored value with `bus_cpu` ORed into bits [1:0].
- R7: A pulse on `rtc_tick` sets `rtc_irq` and bit 4 of the miscellaneous register. A write to index 1 with bit 4 set clears both. If a tick and a clear arrive in the same cycle, the tick wins.
- R8: The control/status register at index 0 always reads as zero.
- R9: These accesses are illegal: a size code other than 3 (8 bytes), a write to index 0, 6 to 9 or 10, an unknown index, and a write to index 1 with bit 4 clear. An illegal access changes no register, and an illegal read returns zero. Each one sets `err_sticky`, which stays set until reset.
- R10: A read request gives `bus_rvalid` and its data on the cycle after the request, for exactly one cycle. A write never raises `bus_rvalid`.
- R11: The register index is `bus_addr >> 6`. An access whose low six address bits are not zero is illegal under R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset from block base |
| bus_size | input | 2 | Access size code: 0=1B, 1=2B, 2=4B, 3=8B |
| bus_cpu | input | 2 | Identifier of the accessing processor |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data |
| bus_rvalid | output | 1 | Read data valid |
| dev_irq | input | 64 | Device interrupt request levels |
| rtc_tick | input | 1 | Timer event pulse |
| cpu_irq | output | 4 | Interrupt output per processor |
| rtc_irq | output | 1 | Timer interrupt output |
| err_sticky | output | 1 | Sticky illegal-access flag |

## Verification
The hardest case to reach is the withdrawal of an interrupt by a mask write while the source is still requesting. The raw line has to stay high and the output has to be seen falling only because the mask changed. To get there, the bench holds a device line high, enables it in two processors' masks, and then clears one mask. It checks that only that processor's output drops. The tick-versus-clear collision is set up by driving the tick pulse in the same cycle as the clear write.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int DATA_W      = 64;
  localparam int STRIDE_LOG2 = 6;
  localparam int RTC_BIT     = 4;

  localparam logic [1:0] SIZE_8B = 2'd3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_MISC,
    SEL_MASK,
    SEL_PEND,
    SEL_RAW
  } reg_sel_e;

endpackage

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
  import irq_router_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_CPU  = 4,
  parameter int CPU_W  = 2
) (
  input  logic                  req,
  input  logic                  we,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [1:0]            size,
  input  logic                  clr_bit,
  output reg_sel_e              sel,
  output logic [CPU_W-1:0]      sel_cpu,
  output logic [N_CPU-1:0]      mask_wr,
  output logic                  misc_clr,
  output logic                  rd_fire,
  output logic                  err_set
);

  localparam int IDX_W = ADDR_W - STRIDE_LOG2;
  localparam logic [IDX_W-1:0] I_CTRL  = IDX_W'(0);
  localparam logic [IDX_W-1:0] I_MISC  = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_MASK0 = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_PEND0 = IDX_W'(2 + N_CPU);
  localparam logic [IDX_W-1:0] I_RAW   = IDX_W'(2 + 2 * N_CPU);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] ofs;
  logic             aligned;
  logic             size_ok;
  logic             bad_write;
  logic             illegal;
  reg_sel_e         raw_sel;

  assign idx     = addr[ADDR_W-1:STRIDE_LOG2];
  assign aligned = (addr[STRIDE_LOG2-1:0] == '0);
  assign size_ok = (size == SIZE_8B);

  always_comb begin
    raw_sel = SEL_NONE;
    ofs     = '0;
    if (idx == I_CTRL) begin
      raw_sel = SEL_CTRL;
    end else if (idx == I_MISC) begin
      raw_sel = SEL_MISC;
    end else if (idx >= I_MASK0 && idx < I_PEND0) begin
      raw_sel = SEL_MASK;
      ofs     = idx - I_MASK0;
    end else if (idx >= I_PEND0 && idx < I_RAW) begin
      raw_sel = SEL_PEND;
      ofs     = idx - I_PEND0;
    end else if (idx == I_RAW) begin
      raw_sel = SEL_RAW;
    end
  end

  always_comb begin
    bad_write = 1'b0;
    if (we) begin
      case (raw_sel)
        SEL_CTRL, SEL_PEND, SEL_RAW: bad_write = 1'b1;
        SEL_MISC:                    bad_write = !clr_bit;
        default:                     bad_write = 1'b0;
      endcase
    end
  end

  assign illegal  = !size_ok || !aligned || (raw_sel == SEL_NONE) || bad_write;
  assign sel      = illegal ? SEL_NONE : raw_sel;
  assign sel_cpu  = ofs[CPU_W-1:0];
  assign rd_fire  = req && !we;
  assign err_set  = req && illegal;
  assign misc_clr = req && we && (sel == SEL_MISC);

  for (genvar p = 0; p < N_CPU; p++) begin : g_wr
    assign mask_wr[p] = req && we && (sel == SEL_MASK) && (sel_cpu == CPU_W'(p));
  end

endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] raw,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] pend_o,
  output logic         irq_o
);

  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_en) mask_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign mask_o = mask_q;
  assign pend_o = mask_q & raw;
  assign irq_o  = |pend_o;

endmodule

// File: rtl/irq_misc_rtc.sv
module irq_misc_rtc
  import irq_router_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clr,
  output logic [DATA_W-1:0] misc_val,
  output logic              rtc_irq
);

  logic rtc_q;
  logic rtc_d;

  always_comb begin
    rtc_d = rtc_q;
    if (clr)  rtc_d = 1'b0;
    if (tick) rtc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rtc_q <= 1'b0;
    else        rtc_q <= rtc_d;
  end

  always_comb begin
    misc_val          = '0;
    misc_val[RTC_BIT] = rtc_q;
  end

  assign rtc_irq = rtc_q;

endmodule

// File: rtl/irq_mask_router.sv
module irq_mask_router
  import irq_router_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_CPU  = 4,
  parameter int CPU_W  = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [CPU_W-1:0]  bus_cpu,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [63:0]       dev_irq,
  input  logic              rtc_tick,
  output logic [N_CPU-1:0]  cpu_irq,
  output logic              rtc_irq,
  output logic              err_sticky
);

  reg_sel_e             sel;
  logic [CPU_W-1:0]     sel_cpu;
  logic [N_CPU-1:0]     mask_wr;
  logic                 misc_clr;
  logic                 rd_fire;
  logic                 err_set;

  logic [DATA_W-1:0]    raw_q;
  logic [DATA_W-1:0]    mask_arr [N_CPU];
  logic [DATA_W-1:0]    pend_arr [N_CPU];
  logic [DATA_W-1:0]    misc_val;

  logic [DATA_W-1:0]    rdata_q, rdata_d;
  logic                 rvalid_q, rvalid_d;
  logic                 err_q, err_d;

  irq_csr_decode #(
    .ADDR_W (ADDR_W),
    .N_CPU  (N_CPU),
    .CPU_W  (CPU_W)
  ) u_dec (
    .req      (bus_req),
    .we       (bus_we),
    .addr     (bus_addr),
    .size     (bus_size),
    .clr_bit  (bus_wdata[RTC_BIT]),
    .sel      (sel),
    .sel_cpu  (sel_cpu),
    .mask_wr  (mask_wr),
    .misc_clr (misc_clr),
    .rd_fire  (rd_fire),
    .err_set  (err_set)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= dev_irq;
  end

  for (genvar p = 0; p < N_CPU; p++) begin : g_cpu
    irq_cpu_slice #(.W(DATA_W)) u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (mask_wr[p]),
      .wdata  (bus_wdata),
      .raw    (raw_q),
      .mask_o (mask_arr[p]),
      .pend_o (pend_arr[p]),
      .irq_o  (cpu_irq[p])
    );
  end

  irq_misc_rtc u_misc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (rtc_tick),
    .clr      (misc_clr && bus_wdata[RTC_BIT]),
    .misc_val (misc_val),
    .rtc_irq  (rtc_irq)
  );

  always_comb begin
    rdata_d  = rdata_q;
    rvalid_d = rd_fire;
    if (rd_fire) begin
      case (sel)
        SEL_MISC: rdata_d = misc_val | DATA_W'(bus_cpu);
        SEL_MASK: rdata_d = mask_arr[sel_cpu];
        SEL_PEND: rdata_d = pend_arr[sel_cpu];
        SEL_RAW:  rdata_d = raw_q;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_comb begin
    err_d = err_q;
    if (err_set) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
      err_q    <= err_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign err_sticky = err_q;

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int ADDR_W = 12,
  parameter int N_CPU  = 4,
  parameter int CPU_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [CPU_W-1:0]  bus_cpu,
  input logic [63:0]       bus_wdata,
  input logic [63:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic [63:0]       dev_irq,
  input logic              rtc_tick,
  input logic [N_CPU-1:0]  cpu_irq,
  input logic              rtc_irq,
  input logic              err_sticky
);

  logic legal_acc;
  logic [ADDR_W-7:0] idx;
  assign idx       = bus_addr[ADDR_W-1:6];
  assign legal_acc = bus_req && bus_size == 2'd3 && bus_addr[5:0] == 6'd0;

  p_quiet_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dev_irq) == 64'd0) |-> (cpu_irq == '0));

  p_rd_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);

  p_no_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req || bus_we) |=> !bus_rvalid);

  p_tick_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_tick |=> rtc_irq);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_acc && bus_we && idx == 1 && bus_wdata[4] && !rtc_tick) |=> !rtc_irq);

  p_ctrl_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_acc && !bus_we && idx == 0) |=> (bus_rdata == 64'd0));

  p_misc_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_acc && !bus_we && idx == 1) |=> (bus_rdata[CPU_W-1:0] == $past(bus_cpu)));

  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

endmodule

bind irq_mask_router irq_router_chk #(
  .ADDR_W (ADDR_W),
  .N_CPU  (N_CPU),
  .CPU_W  (CPU_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_size   (bus_size),
  .bus_cpu    (bus_cpu),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .dev_irq    (dev_irq),
  .rtc_tick   (rtc_tick),
  .cpu_irq    (cpu_irq),
  .rtc_irq    (rtc_irq),
  .err_sticky (err_sticky)
);

// File: tb/tb_irq_mask_router.sv
module tb_irq_mask_router;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req;
  logic        bus_we;
  logic [11:0] bus_addr;
  logic [1:0]  bus_size;
  logic [1:0]  bus_cpu;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata;
  logic        bus_rvalid;
  logic [63:0] dev_irq;
  logic        rtc_tick;
  logic [3:0]  cpu_irq;
  logic        rtc_irq;
  logic        err_sticky;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  irq_mask_router dut (
    .clk (clk), .rst_n (rst_n),
    .bus_req (bus_req), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_size (bus_size), .bus_cpu (bus_cpu), .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid),
    .dev_irq (dev_irq), .rtc_tick (rtc_tick),
    .cpu_irq (cpu_irq), .rtc_irq (rtc_irq), .err_sticky (err_sticky)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] ra(input int idx);
    return 12'(idx << 6);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input logic [1:0] sz = 2'd3);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(posedge clk);
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d,
                    input logic [1:0] cpu = 2'd0, input logic [1:0] sz = 2'd3);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_cpu = cpu; bus_size = sz;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
    chk("R10 rvalid after read", 64'(bus_rvalid), 64'd1);
    bus_req = 1'b0;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    chk("R1 cpu_irq in reset", 64'(cpu_irq), 64'd0);
    chk("R1 rtc_irq in reset", 64'(rtc_irq), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 err after reset", 64'(err_sticky), 64'd0);
    chk("R1 rvalid idle", 64'(bus_rvalid), 64'd0);
    rd(ra(3), d); chk("R1 mask1 zero", d, 64'd0);
    rd(ra(1), d); chk("R1 misc zero", d, 64'd0);
  endtask

  task automatic t_masks;
    logic [63:0] d;
    wr(ra(2), 64'hDEAD_BEEF_0123_4567);
    wr(ra(5), 64'h8000_0000_0000_0001);
    rd(ra(2), d); chk("R5 mask0 value", d, 64'hDEAD_BEEF_0123_4567);
    rd(ra(5), d); chk("R5 mask3 value", d, 64'h8000_0000_0000_0001);
    rd(ra(3), d); chk("R5 mask1 untouched", d, 64'd0);
    rd(ra(2), d, 2'd3); chk("R11 index from addr not cpu", d, 64'hDEAD_BEEF_0123_4567);
    wr(ra(2), 64'd0);
    wr(ra(5), 64'd0);
  endtask

  task automatic t_raw_pend;
    logic [63:0] d;
    @(negedge clk); dev_irq = 64'h0000_0000_0000_00A0;
    @(negedge clk);
    chk("R4 no mask no irq", 64'(cpu_irq), 64'd0);
    rd(ra(10), d); chk("R2 raw follows lines", d, 64'h0000_0000_0000_00A0);
    wr(ra(2), 64'h0000_0000_0000_0020);
    chk("R4 cpu0 irq after mask", 64'(cpu_irq), 64'b0001);
    wr(ra(4), 64'hFFFF_0000_0000_0080);
    chk("R4 cpu0 and cpu2", 64'(cpu_irq), 64'b0101);
    rd(ra(8), d); chk("R3 pend2", d, 64'h0000_0000_0000_0080);
    rd(ra(6), d); chk("R3 pend0", d, 64'h0000_0000_0000_0020);
    rd(ra(7), d); chk("R3 pend1 empty", d, 64'd0);
    @(negedge clk); dev_irq = 64'h0000_0000_0000_0080;
    @(negedge clk);
    chk("R4 line drop withdraws cpu0", 64'(cpu_irq), 64'b0100);
    rd(ra(10), d); chk("R2 raw bit clears", d, 64'h0000_0000_0000_0080);
    wr(ra(2), 64'h0000_0000_0000_0080);
    chk("R4 shared source", 64'(cpu_irq), 64'b0101);
    wr(ra(4), 64'd0);
    chk("R4 mask clear withdraws cpu2 only", 64'(cpu_irq), 64'b0001);
    wr(ra(2), 64'd0);
    @(negedge clk); dev_irq = 64'd0;
  endtask

  task automatic t_misc_rtc;
    logic [63:0] d;
    rd(ra(1), d, 2'd2); chk("R6 misc id 2", d, 64'd2);
    @(negedge clk); rtc_tick = 1'b1;
    @(negedge clk); rtc_tick = 1'b0;
    chk("R7 tick sets rtc", 64'(rtc_irq), 64'd1);
    rd(ra(1), d, 2'd1); chk("R6 R7 misc bit4 and id", d, 64'h11);
    wr(ra(1), 64'h10);
    chk("R7 clear", 64'(rtc_irq), 64'd0);
    rd(ra(1), d, 2'd3); chk("R7 bit4 cleared", d, 64'h3);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = ra(1); bus_wdata = 64'h10; bus_size = 2'd3;
    rtc_tick = 1'b1;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; rtc_tick = 1'b0;
    chk("R7 tick beats clear", 64'(rtc_irq), 64'd1);
    wr(ra(1), 64'h10);
    chk("R9 err still clear", 64'(err_sticky), 64'd0);
  endtask

  task automatic t_ctrl_timing;
    logic [63:0] d;
    rd(ra(0), d); chk("R8 ctrl reads zero", d, 64'd0);
    wr(ra(3), 64'h55);
    chk("R10 no rvalid on write", 64'(bus_rvalid), 64'd0);
    wr(ra(3), 64'd0);
  endtask

  task automatic t_illegal;
    logic [63:0] d;
    wr(ra(3), 64'h77, 2'd2);
    chk("R9 bad size sets err", 64'(err_sticky), 64'd1);
    rd(ra(3), d); chk("R9 bad size no write", d, 64'd0);
    wr(ra(3) | 12'h8, 64'h99);
    rd(ra(3), d); chk("R11 misaligned no write", d, 64'd0);
    rd(ra(3), d, 2'd0, 2'd1); chk("R9 bad size read zero", d, 64'd0);
    @(negedge clk); dev_irq = 64'h1;
    wr(ra(2), 64'h1);
    wr(ra(6), 64'd0);
    rd(ra(6), d); chk("R9 pend write ignored", d, 64'h1);
    wr(ra(10), 64'd0);
    rd(ra(10), d); chk("R9 raw write ignored", d, 64'h1);
    rd(ra(40), d); chk("R9 unknown index reads zero", d, 64'd0);
    @(negedge clk); rtc_tick = 1'b1;
    @(negedge clk); rtc_tick = 1'b0;
    wr(ra(1), 64'h0);
    chk("R9 misc write bit4 clear keeps rtc", 64'(rtc_irq), 64'd1);
    chk("R9 err sticky", 64'(err_sticky), 64'd1);
    chk("R4 cpu0 from src0", 64'(cpu_irq), 64'b0001);
  endtask

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_size = 2'd3; bus_cpu = '0; bus_wdata = '0; dev_irq = '0; rtc_tick = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_masks();
    t_raw_pend();
    t_misc_rtc();
    t_ctrl_timing();
    t_illegal();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule